// File: doc/BRIEF.md
# Snapshot-Read 64-bit Timebase

This block keeps a 64-bit timebase that advances by one on every cycle in which the tick input is high. It runs without stopping and rolls over from all ones to zero. Software reaches it through a synchronous 32-bit register port. On that port it can read the live count, stage a 64-bit start value in two load words, and issue two one-shot commands through the control register.

The count is wider than the data path, so reading the two live words one after the other can mix the halves of two different counts. The snapshot command avoids this. In a single clock edge it copies the whole count into a pair of snapshot words. Software then reads the high snapshot word and the low one in any order, for as long as it needs, and both halves come from the same instant. The load command moves the staged start value into the counter in one edge.

The port takes a word address. Word 0 is control, 1 and 2 are the live count low and high words, 3 and 4 are the load low and high words, and 5 and 6 are the snapshot low and high words. Word 7 is unmapped.

Top module: `tbase64_latched`

## Requirements
- R1: After reset, every register reads 0: control, both live count words, both load words and both snapshot words.
- R2: The count rises by exactly one on each clock edge where tick is 1 and no load command is written. It holds its value on edges where tick is 0.
- R3: The count is 64 bits wide. A carry out of the low word goes into the high word, and all ones rolls over to zero.
- R4: A write to control (word 0) with data bit 0 set and bit 1 clear copies the count into the snapshot words (word 5 low, word 6 high). The value copied is the count as it stood before that edge, even if tick is high on the same edge.
- R5: The snapshot words change only on a snapshot command. Reads, ticks, loads and other writes leave them unchanged.
- R6: A write to control with data bits 1 and 0 both set puts the 64-bit load value into the count on that edge. The load value is word 4 above word 3. On the same edge the load takes the place of any tick increment.
- R7: A write to control with bit 1 set and bit 0 clear neither loads the count nor takes a snapshot.
- R8: Control bits 1 and 0 always read as 0. Control bits 7 to 2 read back the value last written.
- R9: The load words read back what was written. Writes to the live count words (words 1 and 2) are ignored.
- R10: Read data is registered. It shows the addressed word one edge after a cycle with rd_en high, and it holds while rd_en is low. Word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for the current cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
Two actions can land on the same edge as a tick: a snapshot command and a load command. The bench drives tick high in the very cycle it writes each command. For the snapshot, the snapshot words must hold the count from before the edge while the live count moves on by one and keeps ticking. For the load, the live count must equal the load value exactly, with no increment added. Both results are read back after tick has dropped, so the expected values are fixed numbers.

// File: rtl/tb64_pkg.sv
package tb64_pkg;
   localparam int NREG = 7;

   typedef enum logic [2:0] {
      RA_CTRL    = 3'd0,
      RA_CNT_LO  = 3'd1,
      RA_CNT_HI  = 3'd2,
      RA_LD_LO   = 3'd3,
      RA_LD_HI   = 3'd4,
      RA_SNAP_LO = 3'd5,
      RA_SNAP_HI = 3'd6
   } reg_idx_e;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_LOAD_BIT = 1;

   typedef struct packed {
      logic snap;
      logic load;
   } cmd_t;

   function automatic cmd_t decode_cmd(input logic wr_ctrl, input logic [1:0] bits);
      cmd_t c;
      c.snap = wr_ctrl && bits[CMD_GO_BIT] && !bits[CMD_LOAD_BIT];
      c.load = wr_ctrl && bits[CMD_GO_BIT] &&  bits[CMD_LOAD_BIT];
      return c;
   endfunction
endpackage

// File: rtl/tb64_decode.sv
module tb64_decode
   import tb64_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [1:0]    cmd_bits,
   output logic          wr_ctrl,
   output logic [1:0]    wr_ld,
   output cmd_t          cmd
);
   assign wr_ctrl = wr_en && (addr == AW'(RA_CTRL));

   for (genvar w = 0; w < 2; w++) begin : g_ld
      assign wr_ld[w] = wr_en && (addr == AW'(int'(RA_LD_LO) + w));
   end

   assign cmd = decode_cmd(wr_ctrl, cmd_bits);
endmodule

// File: rtl/tb64_counter.sv
module tb64_counter #(
   parameter int CNT_W     = 64,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   localparam int HALF_W = CNT_W / 2;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_inc;

   if (SPLIT_INC) begin : g_split
      logic             lo_carry;
      logic [HALF_W-1:0] lo_next;
      assign {lo_carry, lo_next} = {1'b0, count_q[HALF_W-1:0]} + {{HALF_W{1'b0}}, 1'b1};
      assign count_inc = {count_q[CNT_W-1:HALF_W] + {{(CNT_W-HALF_W-1){1'b0}}, lo_carry}, lo_next};
   end else begin : g_flat
      assign count_inc = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       count_q <= '0;
      else if (load_en) count_q <= load_val;
      else if (tick)    count_q <= count_inc;
   end

   assign count = count_q;
endmodule

// File: rtl/tb64_regs.sv
module tb64_regs #(
   parameter int DATA_W = 32,
   parameter int CTRL_W = 8,
   parameter int CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [1:0]        wr_ld,
   input  logic              snap_cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   output logic [DATA_W-1:0] ctrl_rd,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  snap_val
);
   logic [CTRL_W-1:2] ctrl_q;
   logic [CNT_W-1:0]  load_q;
   logic [CNT_W-1:0]  snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:2];
   end

   for (genvar w = 0; w < 2; w++) begin : g_load
      always_ff @(posedge clk) begin
         if (!rst_n)        load_q[w*DATA_W +: DATA_W] <= '0;
         else if (wr_ld[w]) load_q[w*DATA_W +: DATA_W] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        snap_q <= '0;
      else if (snap_cmd) snap_q <= count;
   end

   assign ctrl_rd  = DATA_W'({ctrl_q, 2'b00});
   assign load_val = load_q;
   assign snap_val = snap_q;
endmodule

// File: rtl/tb64_rdmux.sv
module tb64_rdmux
   import tb64_pkg::*;
#(
   parameter int AW     = 3,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] ctrl_rd,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  load_val,
   input  logic [CNT_W-1:0]  snap_val,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [NREG];
   logic [DATA_W-1:0] sel;

   assign words[RA_CTRL]    = ctrl_rd;
   assign words[RA_CNT_LO]  = count[DATA_W-1:0];
   assign words[RA_CNT_HI]  = count[CNT_W-1:DATA_W];
   assign words[RA_LD_LO]   = load_val[DATA_W-1:0];
   assign words[RA_LD_HI]   = load_val[CNT_W-1:DATA_W];
   assign words[RA_SNAP_LO] = snap_val[DATA_W-1:0];
   assign words[RA_SNAP_HI] = snap_val[CNT_W-1:DATA_W];

   always_comb begin
      sel = '0;
      for (int r = 0; r < NREG; r++)
         if (addr == AW'(r)) sel = words[r];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end
endmodule

// File: rtl/tbase64_latched.sv
module tbase64_latched
   import tb64_pkg::*;
#(
   parameter int AW        = 3,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 64,
   parameter int CTRL_W    = 8,
   parameter bit SPLIT_INC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be twice DATA_W");
   end
   if (AW < 3) begin : g_bad_aw
      $error("AW must reach seven words");
   end
   if (CTRL_W < 3 || CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("CTRL_W out of range");
   end

   logic              wr_ctrl;
   logic [1:0]        wr_ld;
   cmd_t              cmd;
   logic [DATA_W-1:0] ctrl_rd;
   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  load_q;
   logic [CNT_W-1:0]  snap_q;

   tb64_decode #(.AW(AW)) u_dec (
      .wr_en    (wr_en),
      .addr     (addr),
      .cmd_bits (wdata[1:0]),
      .wr_ctrl  (wr_ctrl),
      .wr_ld    (wr_ld),
      .cmd      (cmd)
   );

   tb64_counter #(.CNT_W(CNT_W), .SPLIT_INC(SPLIT_INC)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load_en  (cmd.load),
      .load_val (load_q),
      .count    (count_q)
   );

   tb64_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wr_ld    (wr_ld),
      .snap_cmd (cmd.snap),
      .wdata    (wdata),
      .count    (count_q),
      .ctrl_rd  (ctrl_rd),
      .load_val (load_q),
      .snap_val (snap_q)
   );

   tb64_rdmux #(.AW(AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr     (addr),
      .ctrl_rd  (ctrl_rd),
      .count    (count_q),
      .load_val (load_q),
      .snap_val (snap_q),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/tbase64_latched_chk.sv
module tbase64_latched_chk #(
   parameter int AW     = 3,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_en,
   input logic              rd_en,
   input logic [AW-1:0]     addr,
   input logic [1:0]        cmd_bits,
   input logic [DATA_W-1:0] rd_data,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  load_q,
   input logic [CNT_W-1:0]  snap_q
);
   logic to_ctrl;
   assign to_ctrl = wr_en && (addr == '0);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (to_ctrl && cmd_bits == 2'b11) |=> count_q == $past(load_q)); // R6
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(to_ctrl && cmd_bits == 2'b11)) |=> count_q == $past(count_q) + 1'b1); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !(to_ctrl && cmd_bits == 2'b11)) |=> $stable(count_q)); // R2
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (to_ctrl && cmd_bits == 2'b01) |=> snap_q == $past(count_q)); // R4
   AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_ctrl && cmd_bits == 2'b01) |=> $stable(snap_q)); // R5
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R10
endmodule

bind tbase64_latched tbase64_latched_chk #(.AW(AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .cmd_bits (wdata[1:0]),
   .rd_data  (rd_data),
   .count_q  (count_q),
   .load_q   (load_q),
   .snap_q   (snap_q)
);

// File: tb/tbase64_latched_test.sv
`timescale 1ns/1ps
module tbase64_latched_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   tbase64_latched uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(idx); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = 3'(idx);
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic rd64(input int lo_idx, output logic [63:0] v);
      logic [31:0] hi, lo;
      rd(lo_idx + 1, hi);
      rd(lo_idx, lo);
      v = {hi, lo};
   endtask

   task automatic load64(input logic [63:0] v);
      wr(3, v[31:0]);
      wr(4, v[63:32]);
      wr(0, 32'h3);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int i = 0; i < 7; i++) begin
         rd(i, d);
         check("R1 reset word", 64'(d), 64'h0);
      end
   endtask

   task automatic t_load_count;
      logic [63:0] v;
      logic [31:0] d;
      load64(64'h0123_4567_89AB_CDEF);
      rd64(1, v); check("R6 load value", v, 64'h0123_4567_89AB_CDEF);
      rd64(3, v); check("R9 load readback", v, 64'h0123_4567_89AB_CDEF);
      rd(0, d);   check("R8 cmd bits read 0", 64'(d), 64'h0);
      ticks(5);
      rd64(1, v); check("R2 five ticks", v, 64'h0123_4567_89AB_CDF4);
      repeat (4) @(negedge clk);
      rd64(1, v); check("R2 hold without tick", v, 64'h0123_4567_89AB_CDF4);
   endtask

   task automatic t_wrap;
      logic [63:0] v;
      load64(64'h0000_0000_FFFF_FFFF);
      ticks(1);
      rd64(1, v); check("R3 carry into high word", v, 64'h0000_0001_0000_0000);
      load64(64'hFFFF_FFFF_FFFF_FFFE);
      ticks(3);
      rd64(1, v); check("R3 wrap to zero", v, 64'h1);
   endtask

   task automatic t_snap_tick;
      logic [63:0] v;
      load64(64'h0000_00AA_0000_0100);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 32'h1;
      @(negedge clk);
      wr_en = 1'b0;
      repeat (5) @(negedge clk);
      tick = 1'b0;
      rd64(5, v); check("R4 snapshot before tick", v, 64'h0000_00AA_0000_0100);
      rd64(1, v); check("R2 count ran on", v, 64'h0000_00AA_0000_0106);
      ticks(7);
      wr(3, 32'h5555_5555);
      rd64(5, v); check("R5 snapshot held", v, 64'h0000_00AA_0000_0100);
      rd64(5, v); check("R5 snapshot reread", v, 64'h0000_00AA_0000_0100);
   endtask

   task automatic t_load_tick;
      logic [63:0] v;
      wr(3, 32'h0000_0010);
      wr(4, 32'h0000_0020);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 32'h3;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      rd64(1, v); check("R6 load beats tick", v, 64'h0000_0020_0000_0010);
   endtask

   task automatic t_ctrl_bits;
      logic [63:0] v;
      logic [31:0] d;
      wr(3, 32'hDEAD_0000);
      wr(0, 32'h2);
      rd64(1, v); check("R7 bit1 alone no load", v, 64'h0000_0020_0000_0010);
      rd64(5, v); check("R7 bit1 alone no snapshot", v, 64'h0000_00AA_0000_0100);
      wr(0, 32'hA5);
      rd(0, d); check("R8 upper ctrl bits kept", 64'(d), 64'hA4);
      rd64(5, v); check("R4 snapshot via A5", v, 64'h0000_0020_0000_0010);
      wr(1, 32'h1234_5678);
      wr(2, 32'h9ABC_DEF0);
      rd64(1, v); check("R9 live words read-only", v, 64'h0000_0020_0000_0010);
   endtask

   task automatic t_read_port;
      logic [31:0] d;
      rd(7, d); check("R10 unmapped reads 0", 64'(d), 64'h0);
      rd(0, d);
      @(negedge clk); addr = 3'd4;
      repeat (3) @(negedge clk);
      check("R10 held while idle", 64'(rd_data), 64'hA4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_load_count();
      t_wrap();
      t_snap_tick();
      t_load_tick();
      t_ctrl_bits();
      t_read_port();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule